// File: doc/BRIEF.md
# Serial FIFO Interrupt Cause Unit

This unit watches the occupancy of a serial port's receive and transmit FIFOs and converts it into five interrupt causes: receive overflow, receive level above threshold, receive data left waiting too long, transmit FIFO empty, and transmit level under threshold. Each cause has a status bit and an enable bit; the enabled, active causes are merged into a single interrupt line. A receive-not-empty flag and the transmit fill level are also reported, so software can size a refill burst as depth minus fill.

The FIFOs themselves are not part of the block. It sees them only through their occupancy, the push and pop strobes and the receive FIFO reset. The receive idle limit is counted in character times, using a one-cycle tick from the baud logic. Thresholds and the idle limit come in as quasi-static configuration. The enable register is loaded through a write strobe.

Top module: `uart_fifo_irq`

## Requirements
- R1: While rst_ni is low, irq_o, mask_o and status_o are all zero.
- R2: A push while rx_level_i equals DEPTH sets status bit 0 (overflow) one cycle later. It stays set through pops and level changes, and only rx_fifo_rst_i clears it.
- R3: Status bit 1 equals (rx_level_i > rx_thresh_i), one cycle after the inputs.
- R4: Status bit 2 (idle timeout) rises once rx_level_i is non-zero and tmo_chars_i character ticks have been counted since the last push, pop or FIFO reset. A limit of 1 rises after a single tick. The bit is never set while the receive FIFO is empty. A limit of 0 disables the cause.
- R5: Status bit 3 equals (tx_level_i == 0), one cycle after the input.
- R6: Status bit 4 equals (tx_level_i < tx_thresh_i), one cycle after the inputs.
- R7: irq_o is the OR over all bits of status_o AND mask_o, registered one cycle later.
- R8: A pulse on mask_we_i loads mask_i into mask_o, with bit positions matching status_o. Writing zero disables every cause, so irq_o falls within two cycles. A cause whose enable bit is clear does not raise irq_o.
- R9: rx_not_empty_o equals (rx_level_i != 0), one cycle later, whatever the enable bits hold.
- R10: tx_fill_o equals tx_level_i, one cycle later, so DEPTH minus tx_fill_o is the free transmit space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Load strobe for the enable register |
| mask_i | input | 5 | New enable bits |
| rx_thresh_i | input | LVL_W | Receive threshold |
| tx_thresh_i | input | LVL_W | Transmit threshold |
| tmo_chars_i | input | TMO_W | Receive idle limit in character times, 0 disables |
| char_tick_i | input | 1 | One-cycle pulse per character time |
| rx_level_i | input | LVL_W | Receive FIFO occupancy |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| rx_fifo_rst_i | input | 1 | Receive FIFO reset |
| tx_level_i | input | LVL_W | Transmit FIFO occupancy |
| irq_o | output | 1 | Merged interrupt |
| mask_o | output | 5 | Enable bits |
| status_o | output | 5 | Cause status bits |
| rx_not_empty_o | output | 1 | Receive FIFO holds data |
| tx_fill_o | output | LVL_W | Registered transmit fill level |

## Verification
A stuck or lost overflow flag shows on status_o bit 0 one cycle after the offending push, or at the first pop or reset that should not clear it, or should clear it. A wrong idle counter shows as bit 2 rising one tick too early or late, or not restarting after a pop. A stale enable register or merge term shows on irq_o within two cycles of a mask write, so the irq_o waveform exposes it at once.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_CAUSE = 5;
  typedef enum int unsigned {
    C_RX_OVF   = 0,
    C_RX_THR   = 1,
    C_RX_TMO   = 2,
    C_TX_EMPTY = 3,
    C_TX_LOW   = 4
  } cause_e;
endpackage

// File: rtl/uart_irq_rx.sv
module uart_irq_rx #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             push_i,
  input  logic             fifo_rst_i,
  output logic             ovf_o,
  output logic             thr_o,
  output logic             ne_o
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      thr_o <= 1'b0;
      ne_o  <= 1'b0;
    end else begin
      // sticky until the FIFO itself is reset
      if (fifo_rst_i)                       ovf_o <= 1'b0;
      else if (push_i && level_i == FULL)   ovf_o <= 1'b1;
      thr_o <= level_i > thresh_i;
      ne_o  <= level_i != '0;
    end
  end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned TMO_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic             hit_o
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;
  logic [TMO_W-1:0] cnt_q;
  logic             busy;

  assign busy = level_i != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hit_o <= 1'b0;
    end else begin
      if (restart_i || !busy)              cnt_q <= '0;
      else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      hit_o <= busy && limit_i != '0 && cnt_q >= limit_i;
    end
  end
endmodule

// File: rtl/uart_irq_tx.sv
module uart_irq_tx #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             empty_o,
  output logic             low_o,
  output logic [LVL_W-1:0] fill_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b0;
      low_o   <= 1'b0;
      fill_o  <= '0;
    end else begin
      empty_o <= level_i == '0;
      low_o   <= level_i < thresh_i;
      fill_o  <= level_i;
    end
  end
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TMO_W = 4,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mask_we_i,
  input  logic [NUM_CAUSE-1:0] mask_i,
  input  logic [LVL_W-1:0]     rx_thresh_i,
  input  logic [LVL_W-1:0]     tx_thresh_i,
  input  logic [TMO_W-1:0]     tmo_chars_i,
  input  logic                 char_tick_i,
  input  logic [LVL_W-1:0]     rx_level_i,
  input  logic                 rx_push_i,
  input  logic                 rx_pop_i,
  input  logic                 rx_fifo_rst_i,
  input  logic [LVL_W-1:0]     tx_level_i,
  output logic                 irq_o,
  output logic [NUM_CAUSE-1:0] mask_o,
  output logic [NUM_CAUSE-1:0] status_o,
  output logic                 rx_not_empty_o,
  output logic [LVL_W-1:0]     tx_fill_o
);
  logic [NUM_CAUSE-1:0] mask_q;
  logic [NUM_CAUSE-1:0] pend;
  logic                 irq_q;

  uart_irq_rx #(.DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .level_i    (rx_level_i),
    .thresh_i   (rx_thresh_i),
    .push_i     (rx_push_i),
    .fifo_rst_i (rx_fifo_rst_i),
    .ovf_o      (status_o[C_RX_OVF]),
    .thr_o      (status_o[C_RX_THR]),
    .ne_o       (rx_not_empty_o)
  );

  uart_irq_tmo #(.LVL_W(LVL_W), .TMO_W(TMO_W)) u_tmo (
    .clk_i, .rst_ni,
    .level_i   (rx_level_i),
    .limit_i   (tmo_chars_i),
    .tick_i    (char_tick_i),
    .restart_i (rx_push_i | rx_pop_i | rx_fifo_rst_i),
    .hit_o     (status_o[C_RX_TMO])
  );

  uart_irq_tx #(.LVL_W(LVL_W)) u_tx (
    .clk_i, .rst_ni,
    .level_i  (tx_level_i),
    .thresh_i (tx_thresh_i),
    .empty_o  (status_o[C_TX_EMPTY]),
    .low_o    (status_o[C_TX_LOW]),
    .fill_o   (tx_fill_o)
  );

  for (genvar i = 0; i < NUM_CAUSE; i++) begin : g_pend
    assign pend[i] = status_o[i] & mask_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      irq_q <= |pend;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int unsigned LVL_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_fifo_rst_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] tx_level_i,
  input logic             irq_o,
  input logic [4:0]       mask_o,
  input logic [4:0]       status_o
);
  p_ovf_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !rx_fifo_rst_i) |=> status_o[0]);

  p_ovf_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_rst_i |=> !status_o[0]);

  p_tmo_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> $past(rx_level_i) != '0);

  p_tx_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i == '0) |=> status_o[3]);

  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_o & mask_o)) |=> irq_o);

  p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_o & mask_o)) |=> !irq_o);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_fifo_rst_i (rx_fifo_rst_i),
  .rx_level_i    (rx_level_i),
  .tx_level_i    (tx_level_i),
  .irq_o         (irq_o),
  .mask_o        (mask_o),
  .status_o      (status_o)
);

// File: tb/uart_fifo_irq_bench.sv
module uart_fifo_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LVL_W = 5;
  localparam int TMO_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mask_we = 1'b0;
  logic [4:0] mask_in = '0;
  logic [LVL_W-1:0] rx_thr = '0, tx_thr = '0, rx_lvl = '0, tx_lvl = '0;
  logic [TMO_W-1:0] tmo = '0;
  logic tick = 1'b0, push = 1'b0, pop = 1'b0, frst = 1'b0;
  logic irq, rx_ne;
  logic [4:0] mask_out, status;
  logic [LVL_W-1:0] fill;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_irq #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_uart_fifo_irq (
    .clk_i(clk), .rst_ni(rst_ni), .mask_we_i(mask_we), .mask_i(mask_in),
    .rx_thresh_i(rx_thr), .tx_thresh_i(tx_thr), .tmo_chars_i(tmo),
    .char_tick_i(tick), .rx_level_i(rx_lvl), .rx_push_i(push), .rx_pop_i(pop),
    .rx_fifo_rst_i(frst), .tx_level_i(tx_lvl), .irq_o(irq), .mask_o(mask_out),
    .status_o(status), .rx_not_empty_o(rx_ne), .tx_fill_o(fill)
  );

  // {rx_lvl, rx_thr, tx_lvl, tx_thr, exp{rx_ne, tx_low, tx_empty, rx_thr}}
  localparam logic [23:0] VEC [6] = '{
    {5'd0,  5'd8,  5'd0,  5'd8, 4'b0110},
    {5'd8,  5'd8,  5'd8,  5'd8, 4'b1000},
    {5'd9,  5'd8,  5'd7,  5'd8, 4'b1101},
    {5'd16, 5'd15, 5'd16, 5'd1, 4'b1001},
    {5'd1,  5'd0,  5'd0,  5'd0, 4'b1011},
    {5'd0,  5'd0,  5'd3,  5'd4, 4'b0100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mask(input logic [4:0] m);
    mask_in = m; mask_we = 1'b1;
    cyc(1);
    mask_we = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rx_thr = 5'd8; tx_thr = 5'd8;
    cyc(3);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 mask", mask_out, 0);
    check("R1 status", status, 0);
    rst_ni = 1'b1;
    cyc(1);

    // R3 R5 R6 R9 R10 vector walk, mask all clear
    foreach (VEC[i]) begin
      rx_lvl = VEC[i][23:19]; rx_thr = VEC[i][18:14];
      tx_lvl = VEC[i][13:9];  tx_thr = VEC[i][8:4];
      cyc(1);
      check("R3 rx above thresh", status[1], VEC[i][0]);
      check("R5 tx empty", status[3], VEC[i][1]);
      check("R6 tx below thresh", status[4], VEC[i][2]);
      check("R9 rx not empty", rx_ne, VEC[i][3]);
      check("R10 free space", DEPTH - fill, DEPTH - VEC[i][13:9]);
      check("R8 masked no irq", irq, 0);
    end

    // R7 R8 enable tx empty
    rx_lvl = 0; tx_lvl = 0; tx_thr = 0; rx_thr = 5'd8;
    cyc(2);
    write_mask(5'b01000);
    check("R8 mask load", mask_out, 5'b01000);
    check("R7 irq one cycle late", irq, 0);
    cyc(1);
    check("R7 irq asserted", irq, 1);
    write_mask(5'b00000);
    cyc(1);
    check("R8 zero mask clears irq", irq, 0);
    write_mask(5'b00001);
    cyc(3);
    check("R8 disabled cause no irq", irq, 0);

    // R2 overflow
    rx_lvl = 5'd16; push = 1'b1; cyc(1); push = 1'b0;
    check("R2 overflow set", status[0], 1);
    cyc(1);
    check("R2 overflow irq", irq, 1);
    rx_lvl = 5'd15; pop = 1'b1; cyc(3); pop = 1'b0;
    rx_lvl = 5'd4; cyc(2);
    check("R2 pop does not clear", status[0], 1);
    rx_lvl = 0; frst = 1'b1; cyc(1); frst = 1'b0;
    check("R2 fifo reset clears", status[0], 0);
    cyc(1);
    check("R2 irq falls", irq, 0);

    // R4 timeout, limit 1
    write_mask(5'b00100);
    tmo = 4'd1; rx_lvl = 5'd2; push = 1'b1; cyc(1); push = 1'b0;
    cyc(3);
    check("R4 no tick no timeout", status[2], 0);
    pulse_tick(); cyc(1);
    check("R4 limit 1 after one tick", status[2], 1);
    cyc(1);
    check("R4 timeout irq", irq, 1);
    pop = 1'b1; rx_lvl = 5'd1; cyc(1); pop = 1'b0;
    cyc(1);
    check("R4 pop restarts", status[2], 0);
    // limit 3
    tmo = 4'd3;
    pulse_tick(); cyc(1); pulse_tick(); cyc(2);
    check("R4 two of three ticks", status[2], 0);
    pulse_tick(); cyc(1);
    check("R4 three ticks", status[2], 1);
    // empty FIFO never times out
    rx_lvl = 0; pop = 1'b1; cyc(1); pop = 1'b0;
    for (int k = 0; k < 5; k++) begin pulse_tick(); cyc(1); end
    check("R4 empty no timeout", status[2], 0);
    // limit 0 disables
    tmo = 0; rx_lvl = 5'd3; push = 1'b1; cyc(1); push = 1'b0;
    for (int k = 0; k < 4; k++) begin pulse_tick(); cyc(1); end
    check("R4 zero limit disabled", status[2], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule